// File: doc/BRIEF.md
# DMA Channel Request Qualifier

This block sits in front of a single DMA channel and decides when a transfer may begin. Three request sources feed it: an asynchronous external request pin, and two on-chip serial request lines (receive buffer full and transmit buffer empty). A two-bit field picks which source is active. The external pin is synchronized first. It is then interpreted either as a level, active low or active high, or as an edge, falling or rising.

A qualified request produces a one-cycle start pulse. It does so only while the channel enable and the master enable are set and the end, NMI and address-error flags are all clear. After the pulse, the block waits for the channel's accept strobe before it will issue another. An edge request that has been seen is held until that accept arrives. A level request is looked at again after every accept.

The block also decodes the addressing bits into three outputs. One says whether the channel works in single or dual address mode. The other two say, in single mode, whether the acknowledge strobe belongs to the read cycle or to the write cycle. The source of the request does not need to be the source or the destination of the data moved.

Top module: `dma_req_qual`

## Requirements
- R1: With `det_edge`=0 the external pin is a level request. `det_high`=0 means active low and `det_high`=1 means active high. A pin change made just before a rising clock edge produces `xfer_start` after the third rising edge.
- R2: With `det_edge`=1 the external pin is an edge request. `det_high`=0 selects the falling edge and `det_high`=1 selects the rising edge. Each selected edge yields exactly one start, after the third rising clock edge, and the opposite edge yields none.
- R3: A start is issued only while `ch_enable`=1, `dma_master_en`=1, `xfer_end_flag`=0, `nmi_flag`=0 and `addr_err_flag`=0. If any of these is false, a pending edge request is discarded, and an edge seen during that time is dropped.
- R4: `src_sel` chooses the request source: 0 is the external pin, 1 is `rx_full_req`, 2 is `tx_empty_req` and 3 is none. A source that is not selected never causes a start.
- R5: `xfer_start` is high for exactly one cycle. No further start follows until `xfer_accept` is seen or the enable conditions drop.
- R6: An edge request stays pending until `xfer_accept`. A pin held at its new level afterwards does not start again. An edge that is detected in the same cycle as `xfer_accept` is kept and starts the next transfer.
- R7: A level request that is still active when `xfer_accept` arrives starts a new transfer one cycle after the accepting clock edge.
- R8: `single_mode` equals `addr_single`. With `addr_single`=0 both acknowledge outputs are 0. With `addr_single`=1, `ack_on_write`=0 raises `dack_read_cyc` and `ack_on_write`=1 raises `dack_write_cyc`.
- R9: Reset clears the start output, the pending request and the edge history. An external pin already at its active level when reset ends causes no edge start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dreq_pin | input | 1 | External request pin, asynchronous |
| rx_full_req | input | 1 | Serial receive-full request |
| tx_empty_req | input | 1 | Serial transmit-empty request |
| src_sel | input | 2 | Request source select |
| det_edge | input | 1 | External detection: 0 level, 1 edge |
| det_high | input | 1 | External polarity: 1 high/rising, 0 low/falling |
| ch_enable | input | 1 | Channel enable |
| dma_master_en | input | 1 | Master DMA enable |
| xfer_end_flag | input | 1 | Transfer-end flag |
| nmi_flag | input | 1 | NMI flag |
| addr_err_flag | input | 1 | Address-error flag |
| addr_single | input | 1 | 1 selects single address mode |
| ack_on_write | input | 1 | Acknowledge in write cycle when 1 |
| xfer_accept | input | 1 | Channel accepted the started transfer |
| xfer_start | output | 1 | One-cycle transfer start pulse |
| single_mode | output | 1 | Single address mode active |
| dack_read_cyc | output | 1 | Acknowledge belongs to the read cycle |
| dack_write_cyc | output | 1 | Acknowledge belongs to the write cycle |

## Verification
Two events can fall in the same clock cycle: the channel's accept strobe, which frees the block, and a newly detected external edge. The bench provokes this by timing a pin transition so that its synchronized edge reaches the detector on the exact cycle `xfer_accept` is high. It then expects no start in that cycle and a start one cycle later, which shows that the new edge survived the clear. A variant drops the channel enable in the cycle after the collision, and the bench expects that pending edge to vanish with no start at all.

// File: rtl/dma_req_qual.sv
module dma_req_qual #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dreq_pin,
  input  logic       rx_full_req,
  input  logic       tx_empty_req,
  input  logic [1:0] src_sel,
  input  logic       det_edge,
  input  logic       det_high,
  input  logic       ch_enable,
  input  logic       dma_master_en,
  input  logic       xfer_end_flag,
  input  logic       nmi_flag,
  input  logic       addr_err_flag,
  input  logic       addr_single,
  input  logic       ack_on_write,
  input  logic       xfer_accept,
  output logic       xfer_start,
  output logic       single_mode,
  output logic       dack_read_cyc,
  output logic       dack_write_cyc
);
  localparam int PRIME_W = $clog2(SYNC_STAGES + 2);
  localparam logic [PRIME_W-1:0] PRIME_DONE = PRIME_W'(SYNC_STAGES + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   hist_q;
  logic [PRIME_W-1:0]     prime_q;
  logic                   pend_q;
  logic                   busy_q;
  logic                   req;

  wire ext_now  = sync_q[SYNC_STAGES-1];
  wire primed   = (prime_q == PRIME_DONE);
  wire rise     = ext_now & ~hist_q;
  wire fall     = ~ext_now & hist_q;
  wire edge_hit = primed & (det_high ? rise : fall);
  wire lvl_hit  = primed & (det_high ? ext_now : ~ext_now);
  wire go_ok    = ch_enable & dma_master_en & ~xfer_end_flag & ~nmi_flag & ~addr_err_flag;
  wire ext_edge = (src_sel == 2'd0) & det_edge;
  wire fire     = go_ok & ~busy_q & req;

  always_comb begin
    case (src_sel)
      2'd0:    req = det_edge ? (pend_q | edge_hit) : lvl_hit;
      2'd1:    req = rx_full_req;
      2'd2:    req = tx_empty_req;
      default: req = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q     <= '0;
      hist_q     <= 1'b0;
      prime_q    <= '0;
      pend_q     <= 1'b0;
      busy_q     <= 1'b0;
      xfer_start <= 1'b0;
    end else begin
      sync_q     <= {sync_q[SYNC_STAGES-2:0], dreq_pin};
      hist_q     <= ext_now;
      if (!primed) prime_q <= prime_q + PRIME_W'(1);
      xfer_start <= fire;

      if (!go_ok)           busy_q <= 1'b0;
      else if (fire)        busy_q <= 1'b1;
      else if (xfer_accept) busy_q <= 1'b0;

      if (!go_ok || !ext_edge)      pend_q <= 1'b0;
      else if (edge_hit)            pend_q <= 1'b1;
      else if (xfer_accept && busy_q) pend_q <= 1'b0;
    end
  end

  assign single_mode    = addr_single;
  assign dack_read_cyc  = addr_single & ~ack_on_write;
  assign dack_write_cyc = addr_single & ack_on_write;
endmodule

// File: rtl/dma_req_qual_chk.sv
module dma_req_qual_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] src_sel,
  input logic       ch_enable,
  input logic       dma_master_en,
  input logic       xfer_end_flag,
  input logic       nmi_flag,
  input logic       addr_err_flag,
  input logic       addr_single,
  input logic       xfer_accept,
  input logic       xfer_start,
  input logic       single_mode,
  input logic       dack_read_cyc,
  input logic       dack_write_cyc
);
  wire ok_now = ch_enable & dma_master_en & ~xfer_end_flag & ~nmi_flag & ~addr_err_flag;
  logic outst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) outst_q <= 1'b0;
    else        outst_q <= (outst_q | xfer_start) & ~(xfer_accept | ~ok_now);
  end

  assert_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |=> !xfer_start);

  assert_wait_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |-> !outst_q);

  assert_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |-> $past(ok_now));

  assert_no_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |-> ($past(src_sel) != 2'd3));

  assert_dack_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dack_read_cyc || dack_write_cyc) |-> (single_mode && addr_single));

  assert_dack_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(dack_read_cyc && dack_write_cyc));

  always @(negedge clk) begin
    if (!rst_n) begin
      assert_reset_quiet_R9: assert (!xfer_start);
    end
  end
endmodule

bind dma_req_qual dma_req_qual_chk chk (.*);

// File: tb/tb_dma_req_qual.sv
module tb_dma_req_qual;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dreq_pin = 1'b1;
  logic rx_full_req = 1'b0, tx_empty_req = 1'b0;
  logic [1:0] src_sel = 2'd0;
  logic det_edge = 1'b1, det_high = 1'b1;
  logic ch_enable = 1'b1, dma_master_en = 1'b1;
  logic xfer_end_flag = 1'b0, nmi_flag = 1'b0, addr_err_flag = 1'b0;
  logic addr_single = 1'b0, ack_on_write = 1'b0, xfer_accept = 1'b0;
  logic xfer_start, single_mode, dack_read_cyc, dack_write_cyc;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  dma_req_qual dut (.*);

  // [15:14] src, 13 rx, 12 tx, 11 ch_en, 10 master, 9 end, 8 nmi, 7 aerr,
  // 6 single, 5 ack_wr, 4 -, 3 exp start, 2 exp single, 1 exp rd, 0 exp wr
  localparam int NV = 12;
  localparam logic [15:0] VEC [NV] = '{
    16'b01_10_11_000_00_0_1000,
    16'b01_01_11_000_01_0_0000,
    16'b10_01_11_000_10_0_1110,
    16'b10_10_11_000_11_0_0101,
    16'b11_11_11_000_00_0_0000,
    16'b00_11_11_000_00_0_0000,
    16'b01_10_01_000_00_0_0000,
    16'b01_10_10_000_00_0_0000,
    16'b01_10_11_100_00_0_0000,
    16'b01_10_11_010_00_0_0000,
    16'b01_10_11_001_10_0_0110,
    16'b10_01_11_000_11_0_1101
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b", what, act, exp);
    end
  endtask

  task automatic accept_pulse();
    xfer_accept = 1'b1;
    tick();
    xfer_accept = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    chk("R9 start in reset", xfer_start, 1'b0);
    chk("R8 dual mode in reset", single_mode, 1'b0);
    tick();
    rst_n = 1'b1;
    for (int k = 0; k < 6; k++) begin
      tick();
      chk("R9 no spurious edge after reset", xfer_start, 1'b0);
    end

    det_edge = 1'b0; det_high = 1'b0;
    tick();
    for (int i = 0; i < NV; i++) begin
      logic [15:0] v;
      v = VEC[i];
      src_sel = v[15:14]; rx_full_req = v[13]; tx_empty_req = v[12];
      ch_enable = v[11]; dma_master_en = v[10]; xfer_end_flag = v[9];
      nmi_flag = v[8]; addr_err_flag = v[7]; addr_single = v[6]; ack_on_write = v[5];
      tick();
      chk($sformatf("R4 R3 vector %0d start", i), xfer_start, v[3]);
      chk($sformatf("R8 vector %0d single", i), single_mode, v[2]);
      chk($sformatf("R8 vector %0d dack read", i), dack_read_cyc, v[1]);
      chk($sformatf("R8 vector %0d dack write", i), dack_write_cyc, v[0]);
      rx_full_req = 1'b0; tx_empty_req = 1'b0;
      accept_pulse();
      tick();
    end
    src_sel = 2'd0; ch_enable = 1'b1; dma_master_en = 1'b1;
    xfer_end_flag = 1'b0; nmi_flag = 1'b0; addr_err_flag = 1'b0;
    addr_single = 1'b0; ack_on_write = 1'b0;
    tick();

    dreq_pin = 1'b0;
    tick(); chk("R1 low level latency 1", xfer_start, 1'b0);
    tick(); chk("R1 low level latency 2", xfer_start, 1'b0);
    tick(); chk("R1 low level start", xfer_start, 1'b1);
    tick(); chk("R5 single cycle pulse", xfer_start, 1'b0);
    tick(); tick(); chk("R5 held off until accept", xfer_start, 1'b0);
    xfer_accept = 1'b1;
    tick(); chk("R7 no start on accept edge", xfer_start, 1'b0);
    xfer_accept = 1'b0;
    tick(); chk("R7 level restarts after accept", xfer_start, 1'b1);
    dreq_pin = 1'b1;
    tick(); tick(); tick();
    accept_pulse();
    tick(); tick(); chk("R1 inactive level no start", xfer_start, 1'b0);

    det_high = 1'b1;
    tick(); chk("R1 high level start", xfer_start, 1'b1);
    xfer_accept = 1'b1; det_high = 1'b0;
    tick(); xfer_accept = 1'b0;
    tick(); chk("R1 high pin under low polarity", xfer_start, 1'b0);

    det_edge = 1'b1; det_high = 1'b1;
    dreq_pin = 1'b0;
    tick(); tick(); tick(); chk("R2 falling ignored in rising mode", xfer_start, 1'b0);
    dreq_pin = 1'b1;
    tick(); tick(); chk("R2 rising latency", xfer_start, 1'b0);
    tick(); chk("R2 rising edge start", xfer_start, 1'b1);
    tick(); tick(); tick(); chk("R5 no repeat before accept", xfer_start, 1'b0);
    accept_pulse();
    for (int k = 0; k < 3; k++) begin
      tick();
      chk("R6 held level does not re-fire", xfer_start, 1'b0);
    end

    det_high = 1'b0;
    tick(); chk("R2 polarity switch no edge", xfer_start, 1'b0);
    dreq_pin = 1'b0;
    tick(); tick(); chk("R2 falling latency", xfer_start, 1'b0);
    tick(); chk("R2 falling edge start", xfer_start, 1'b1);

    dreq_pin = 1'b1;
    tick(); tick(); tick(); chk("R2 rising ignored in falling mode", xfer_start, 1'b0);
    dreq_pin = 1'b0;
    tick(); tick();
    xfer_accept = 1'b1;
    tick(); chk("R6 no start in collision cycle", xfer_start, 1'b0);
    xfer_accept = 1'b0;
    tick(); chk("R6 edge at accept kept", xfer_start, 1'b1);

    dreq_pin = 1'b1;
    tick(); tick(); tick();
    dreq_pin = 1'b0;
    tick(); tick();
    xfer_accept = 1'b1;
    tick(); chk("R6 collision again", xfer_start, 1'b0);
    xfer_accept = 1'b0; ch_enable = 1'b0;
    tick(); chk("R3 disabled no start", xfer_start, 1'b0);
    ch_enable = 1'b1;
    for (int k = 0; k < 3; k++) begin
      tick();
      chk("R3 pending cleared by disable", xfer_start, 1'b0);
    end

    nmi_flag = 1'b1;
    dreq_pin = 1'b1;
    tick(); tick(); tick();
    dreq_pin = 1'b0;
    tick(); tick(); tick();
    nmi_flag = 1'b0;
    for (int k = 0; k < 3; k++) begin
      tick();
      chk("R3 edge while disabled dropped", xfer_start, 1'b0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule